// File: doc/BRIEF.md
# Bit-exact 8-point inverse DCT pipeline

This block computes a one-dimensional 8-point inverse discrete cosine transform on eight signed 16-bit coefficients. Its arithmetic is fixed to the last bit, so that any other implementation that follows the same rules gives identical results. The transform is a three-stage butterfly and rotation graph. Every constant multiply keeps only the upper half of a 16-by-16 product. Every sum and difference wraps in two's complement and never clamps. The two operands that feed each cos(pi/4) scaling are cut to 16 bits before they are multiplied. Because the arithmetic wraps rather than saturates, the operations may be reordered without changing a single output bit. The pipeline depends on that property.

A caller sends one coefficient vector per valid/ready transfer and receives one result vector per transfer three cycles later. When the consumer holds off, the whole pipeline freezes in place. A two-dimensional transform is built by running this block over rows and then columns. That sequencing happens outside the block.

Top module: `idct8_core`

## Requirements
- R1: Every addition and subtraction in the graph produces the low 16 bits of the exact two's complement result. A sum above 32767 or below -32768 wraps and is never clamped. For example, lane 0 = 32767 with lane 4 = 1 gives an even sum of -32768.
- R2: A constant multiply of operand a by unsigned 16-bit constant k gives floor(a*k / 65536), which is an arithmetic right shift by 16, truncated to 16 bits. The constants are k1=64277, k2=60547, k3=54491, k4=46341, k5=36410, k6=25080 and k7=12785. A DC input of -1000 in lane 0 alone therefore gives -708 on every output lane.
- R3: The even terms are e_sum = k4-scale of wrap16(Y0+Y4) and e_dif = k4-scale of wrap16(Y0-Y4). With Y0=1000 and all other lanes zero, every output lane is 707.
- R4: The rotations in stage one are computed as follows. a2 = k6*Y2 - k2*Y6 and a3 = k2*Y2 + k6*Y6. b4 = k7*Y1 - k1*Y7 and b7 = k1*Y1 + k7*Y7. b5 = k3*Y5 - k5*Y3 and b6 = k5*Y5 + k3*Y3. Each product is scaled as in R2 before it is added or subtracted.
- R5: Stage two forms c4 = b4+b5 and c7 = b7+b6. It also forms c5 = k4-scale of wrap16(b4-b5) and c6 = k4-scale of wrap16(b7-b6). Each difference is cut to 16 bits before it is multiplied.
- R6: The output stage first forms p0 = e_sum+a3, p3 = e_sum-a3, p1 = e_dif+a2, p2 = e_dif-a2, q6 = c6+c5 and q5 = c6-c5. The outputs are then X0=p0+c7, X1=p1+q6, X2=p2+q5, X3=p3+c4, X4=p3-c4, X5=p2-q5, X6=p1-q6 and X7=p0-c7.
- R7: Lane i of both in_coef and out_res occupies bits [16*i+15:16*i]. Y0 and X0 sit in the least significant lane.
- R8: With out_ready held high, a vector accepted at one clock edge appears on out_res with out_valid high after exactly three edges. A new vector can be accepted on every cycle.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_res holds its value. When the pipeline is full and stalled, in_ready is low.
- R10: While rst_n is low, out_valid and in_ready are low. After rst_n rises, in_ready stays low for one more negative edge and is high from the second one on.
- R11: Vectors leave in the order they were accepted, and none is lost or duplicated under any pattern of in_valid and out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A coefficient vector is offered |
| in_ready | output | 1 | The block accepts the offered vector at this edge |
| in_coef | input | 128 | Eight signed 16-bit coefficients, lane i at bits 16i+15..16i |
| out_valid | output | 1 | out_res holds a result vector |
| out_ready | input | 1 | The consumer takes the result at this edge |
| out_res | output | 128 | Eight signed 16-bit outputs, lane i at bits 16i+15..16i |

## Verification
The hardest case to reach from the ports is an internal wrap that moderate inputs never cause, above all the stage-two difference that is cut to 16 bits before its k4 multiply. To reach it, the stimulus mixes full-range random lanes with lanes drawn from the extremes -32768, 32767, -1 and 0. It also adds a directed vector that pushes the odd rotations to opposite limits. A reference model that wraps after every integer operation checks each result. Random gaps on in_valid and random holds on out_ready run at the same time, so wrapped values also pass through full, stalled pipeline states.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

  localparam int SAMP_W  = 16;
  localparam int LANES   = 8;
  localparam int CONST_W = 16;
  localparam int FRAC_W  = 16;
  localparam int PROD_W  = SAMP_W + CONST_W + 1;

  typedef logic signed [SAMP_W-1:0] samp_t;
  typedef samp_t [LANES-1:0]        vec_t;
  typedef logic [CONST_W-1:0]       kcoef_t;

  // cos(n*pi/16) scaled by 2^16, unsigned
  localparam kcoef_t K_C1 = 16'd64277;
  localparam kcoef_t K_C2 = 16'd60547;
  localparam kcoef_t K_C3 = 16'd54491;
  localparam kcoef_t K_C4 = 16'd46341;
  localparam kcoef_t K_C5 = 16'd36410;
  localparam kcoef_t K_C6 = 16'd25080;
  localparam kcoef_t K_C7 = 16'd12785;

  // signed sample times unsigned constant, high word kept (floor shift)
  function automatic samp_t kmul(input samp_t a, input kcoef_t k);
    logic signed [PROD_W-1:0] ax;
    logic signed [PROD_W-1:0] kx;
    logic signed [PROD_W-1:0] pr;
    ax = PROD_W'(a);
    kx = $signed({{(PROD_W-CONST_W){1'b0}}, k});
    pr = ax * kx;
    return samp_t'(pr >>> FRAC_W);
  endfunction

endpackage

// File: rtl/idct8_rst_sync.sv
module idct8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/idct8_stage_rot.sv
// Stage one: even pair scaled by k4 after a 16-bit cut, plus the three rotations.
module idct8_stage_rot
  import idct8_pkg::*;
(
  input  vec_t y_i,
  output vec_t t_o
);

  samp_t ev_sum;
  samp_t ev_dif;

  always_comb begin
    ev_sum = y_i[0] + y_i[4];          // wraps, R1
    ev_dif = y_i[0] - y_i[4];
    t_o[0] = kmul(ev_sum, K_C4);       // R3
    t_o[1] = kmul(ev_dif, K_C4);
    t_o[2] = kmul(y_i[2], K_C6) - kmul(y_i[6], K_C2);   // R4
    t_o[3] = kmul(y_i[2], K_C2) + kmul(y_i[6], K_C6);
    t_o[4] = kmul(y_i[1], K_C7) - kmul(y_i[7], K_C1);
    t_o[5] = kmul(y_i[5], K_C3) - kmul(y_i[3], K_C5);
    t_o[6] = kmul(y_i[5], K_C5) + kmul(y_i[3], K_C3);
    t_o[7] = kmul(y_i[1], K_C1) + kmul(y_i[7], K_C7);
  end

endmodule

// File: rtl/idct8_stage_odd.sv
// Stage two: odd-half butterflies, each difference cut to 16 bits before k4.
module idct8_stage_odd
  import idct8_pkg::*;
(
  input  vec_t t_i,
  output vec_t t_o
);

  samp_t d45;
  samp_t d76;

  always_comb begin
    t_o[0] = t_i[0];
    t_o[1] = t_i[1];
    t_o[2] = t_i[2];
    t_o[3] = t_i[3];
    d45    = t_i[4] - t_i[5];          // R5
    d76    = t_i[7] - t_i[6];
    t_o[4] = t_i[4] + t_i[5];
    t_o[5] = kmul(d45, K_C4);
    t_o[6] = kmul(d76, K_C4);
    t_o[7] = t_i[7] + t_i[6];
  end

endmodule

// File: rtl/idct8_stage_out.sv
// Stage three: even/odd recombination and final output butterflies.
module idct8_stage_out
  import idct8_pkg::*;
(
  input  vec_t t_i,
  output vec_t x_o
);

  samp_t p0, p1, p2, p3, q5, q6;

  always_comb begin
    p0 = t_i[0] + t_i[3];
    p3 = t_i[0] - t_i[3];
    p1 = t_i[1] + t_i[2];
    p2 = t_i[1] - t_i[2];
    q6 = t_i[6] + t_i[5];
    q5 = t_i[6] - t_i[5];
    x_o[0] = p0 + t_i[7];              // R6
    x_o[1] = p1 + q6;
    x_o[2] = p2 + q5;
    x_o[3] = p3 + t_i[4];
    x_o[4] = p3 - t_i[4];
    x_o[5] = p2 - q5;
    x_o[6] = p1 - q6;
    x_o[7] = p0 - t_i[7];
  end

endmodule

// File: rtl/idct8_stage_reg.sv
// One pipeline slot: reset valid flag, reset-less data with written-out enable.
module idct8_stage_reg
  import idct8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic vld_i,
  input  vec_t d_i,
  output logic vld_o,
  output vec_t d_o
);

  logic vld_q;
  logic vld_d;
  logic ld;
  vec_t dat_q;

  always_comb begin
    vld_d = vld_q;
    if (adv_i) vld_d = vld_i;
  end

  assign ld = adv_i && vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ld) dat_q <= d_i;
  end

  assign vld_o = vld_q;
  assign d_o   = dat_q;

endmodule

// File: rtl/idct8_core.sv
module idct8_core
  import idct8_pkg::*;
#(
  parameter  int RST_SYNC_STAGES = 2,
  localparam int VEC_W = SAMP_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_coef,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_res
);

  localparam int NSTG = 3;

  logic            rst_sync_n;
  logic            adv;
  logic [NSTG:0]   vld;
  vec_t            stg_q [0:NSTG];
  vec_t            stg_c [0:NSTG-1];

  idct8_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // whole-pipeline stall: advance unless the last slot is held
  assign adv      = !vld[NSTG] || out_ready;
  assign in_ready = adv && rst_sync_n;
  assign vld[0]   = in_valid && rst_sync_n;
  assign stg_q[0] = in_coef;

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    if (s == 0) begin : g_rot
      idct8_stage_rot u_fn (.y_i(stg_q[s]), .t_o(stg_c[s]));
    end else if (s == 1) begin : g_odd
      idct8_stage_odd u_fn (.t_i(stg_q[s]), .t_o(stg_c[s]));
    end else begin : g_out
      idct8_stage_out u_fn (.t_i(stg_q[s]), .x_o(stg_c[s]));
    end

    idct8_stage_reg u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .adv_i (adv),
      .vld_i (vld[s]),
      .d_i   (stg_c[s]),
      .vld_o (vld[s+1]),
      .d_o   (stg_q[s+1])
    );
  end

  assign out_valid = vld[NSTG];
  assign out_res   = stg_q[NSTG];

endmodule

// File: rtl/idct8_chk.sv
module idct8_chk #(
  parameter int VEC_W = 128,
  parameter int DEPTH = 3
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_res
);

  logic [3:0] occ;
  logic       in_fire;
  logic       out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) occ <= '0;
    else             occ <= occ + 4'(in_fire) - 4'(out_fire);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res)); // R9

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (occ == 4'(DEPTH)) && !out_ready |-> !in_ready); // R9

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    occ <= 4'(DEPTH)); // R8

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> occ != 4'd0); // R11

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> !$isunknown(out_res)); // R6

endmodule

bind idct8_core idct8_chk #(.VEC_W(VEC_W), .DEPTH(NSTG)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_res    (out_res)
);

// File: tb/tb_idct8_core.sv
`timescale 1ns/1ps
module tb_idct8_core;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] in_coef;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_res;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [127:0] exp_q[$];
  string        tag_q[$];
  string        cur_tag = "R11";
  logic         held = 0;
  logic [127:0] held_res = '0;
  logic         got_out = 0;
  logic [127:0] last_out = '0;

  idct8_core dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // ---------------- reference model (integers, wrap after each op) --------
  function automatic int w16(input longint v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int km(input int a, input int k);
    longint p;
    p = longint'(a) * longint'(k);
    return w16(p >>> 16);
  endfunction

  function automatic logic [127:0] ref_idct(input logic [127:0] v);
    int y[8];
    int x[8];
    int es, ed, a2, a3, b4, b5, b6, b7, c4, c5, c6, c7;
    int p0, p1, p2, p3, q5, q6;
    logic [127:0] r;
    for (int i = 0; i < 8; i++) y[i] = int'($signed(v[16*i +: 16]));
    es = km(w16(y[0] + y[4]), 46341);
    ed = km(w16(y[0] - y[4]), 46341);
    a2 = w16(km(y[2], 25080) - km(y[6], 60547));
    a3 = w16(km(y[2], 60547) + km(y[6], 25080));
    b4 = w16(km(y[1], 12785) - km(y[7], 64277));
    b7 = w16(km(y[1], 64277) + km(y[7], 12785));
    b5 = w16(km(y[5], 54491) - km(y[3], 36410));
    b6 = w16(km(y[5], 36410) + km(y[3], 54491));
    c4 = w16(b4 + b5);
    c7 = w16(b7 + b6);
    c5 = km(w16(b4 - b5), 46341);
    c6 = km(w16(b7 - b6), 46341);
    p0 = w16(es + a3); p3 = w16(es - a3);
    p1 = w16(ed + a2); p2 = w16(ed - a2);
    q6 = w16(c6 + c5); q5 = w16(c6 - c5);
    x[0] = w16(p0 + c7); x[7] = w16(p0 - c7);
    x[1] = w16(p1 + q6); x[6] = w16(p1 - q6);
    x[2] = w16(p2 + q5); x[5] = w16(p2 - q5);
    x[3] = w16(p3 + c4); x[4] = w16(p3 - c4);
    for (int i = 0; i < 8; i++) r[16*i +: 16] = x[i][15:0];
    return r;
  endfunction

  function automatic logic [127:0] vec1(input int idx, input int val);
    logic [127:0] r;
    r = '0;
    r[16*idx +: 16] = val[15:0];
    return r;
  endfunction

  function automatic int lane(input logic [127:0] v, input int i);
    return int'($signed(v[16*i +: 16]));
  endfunction

  // ---------------- checking helpers -------------------------------------
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [127:0] cf, input logic ordy);
    logic [127:0] e;
    string tg;
    @(negedge clk);
    in_valid  = iv;
    in_coef   = cf;
    out_ready = ordy;
    #1;
    got_out = 0;
    if (held)
      chk(out_valid && out_res == held_res, "R9", "stalled output not held",
          {127'd0, out_valid} ^ out_res, held_res);
    held     = out_valid && !out_ready;
    held_res = out_res;
    if (in_valid && in_ready) begin
      exp_q.push_back(ref_idct(in_coef));
      tag_q.push_back(cur_tag);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R11", "output with nothing outstanding", out_res, '0);
      end else begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(out_res == e, tg, "result vector mismatch", out_res, e);
      end
      last_out = out_res;
      got_out  = 1;
    end
  endtask

  task automatic one_shot(input logic [127:0] v, input string tg,
                          output int lat, output logic [127:0] res);
    cur_tag = tg;
    step(1, v, 1);
    lat = 0;
    res = '0;
    repeat (10) begin
      step(0, '0, 1);
      lat++;
      if (got_out) begin
        res = last_out;
        break;
      end
    end
  endtask

  task automatic drain();
    repeat (12) step(0, '0, 1);
  endtask

  function automatic int pick_lane(input int mode);
    int r;
    r = int'($urandom);
    case (mode)
      0, 1:    return w16(r);
      2:       return (r % 4001) - 2000;
      default: case (r & 3) 0: return -32768; 1: return 32767; 2: return -1; default: return 0; endcase
    endcase
  endfunction

  // ---------------- watchdog ---------------------------------------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ---------------------------------------------
  initial begin
    int lat;
    int nacc;
    int nout;
    int nrdy;
    logic [127:0] res;
    logic [127:0] v;
    bit ok;

    rst_n = 0; in_valid = 0; in_coef = '0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !in_ready, "R10", "idle during reset",
        {126'd0, out_valid, in_ready}, '0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!in_ready, "R10", "ready one edge after release", {127'd0, in_ready}, '0);
    @(negedge clk); #1;
    chk(in_ready && !out_valid, "R10", "ready two edges after release",
        {126'd0, out_valid, in_ready}, 128'd1);

    // R6: zero in gives zero out
    one_shot('0, "R6", lat, res);
    chk(res == '0, "R6", "zero vector", res, '0);
    // R8: latency
    chk(lat == 3, "R8", "latency in cycles", 128'(lat), 128'd3);

    // R3: positive DC
    one_shot(vec1(0, 1000), "R3", lat, res);
    ok = 1;
    for (int i = 0; i < 8; i++) if (lane(res, i) != 707) ok = 0;
    chk(ok, "R3", "DC 1000 gives 707 on all lanes", res, {8{16'd707}});

    // R2: negative DC floors
    one_shot(vec1(0, -1000), "R2", lat, res);
    ok = 1;
    for (int i = 0; i < 8; i++) if (lane(res, i) != -708) ok = 0;
    chk(ok, "R2", "DC -1000 gives -708 on all lanes", res, {8{16'hFD3C}});

    // R1: even sum wraps instead of saturating
    one_shot(vec1(0, 32767) | vec1(4, 1), "R1", lat, res);
    chk(lane(res, 0) == -23171 && lane(res, 1) == 23169, "R1",
        "wrapped even sum lanes 0 and 1", res, {96'd0, 16'(23169), 16'(-23171)});

    // R5: odd rotations driven to opposite limits
    one_shot(vec1(1, 32767) | vec1(5, -32768) | vec1(3, 32767) | vec1(7, -32768),
             "R5", lat, res);
    one_shot(vec1(1, -32768) | vec1(5, 32767) | vec1(3, -32768) | vec1(7, 32767),
             "R5", lat, res);

    // R4: each rotation input alone
    foreach (v[i]) if (i < 8) begin end
    for (int i = 1; i < 8; i++) if (i != 4) one_shot(vec1(i, 20000), "R4", lat, res);

    // R7: single-lane impulses locate each lane
    for (int i = 0; i < 8; i++) one_shot(vec1(i, -12345), "R7", lat, res);

    // R8: back-to-back acceptance
    cur_tag = "R8";
    nacc = 0; nout = 0; nrdy = 0;
    for (int k = 0; k < 16; k++) begin
      step(1, vec1(k % 8, 100 * k + 7), 1);
      if (in_ready) nrdy++;
      if (got_out) nout++;
    end
    for (int k = 0; k < 3; k++) begin
      step(0, '0, 1);
      if (got_out) nout++;
    end
    chk(nrdy == 16, "R8", "ready on every cycle", 128'(nrdy), 128'd16);
    chk(nout == 16, "R8", "one output per cycle", 128'(nout), 128'd16);

    // R9: full stall
    cur_tag = "R9";
    for (int k = 0; k < 6; k++) step(1, vec1(2, 3000 + k), 0);
    chk(!in_ready && out_valid, "R9", "full pipeline blocks input",
        {126'd0, out_valid, in_ready}, 128'd2);
    drain();

    // R11 plus full-range random with backpressure
    cur_tag = "R11";
    for (int k = 0; k < 600; k++) begin
      v = '0;
      for (int i = 0; i < 8; i++) v[16*i +: 16] = 16'(pick_lane(int'($urandom % 4)));
      step(($urandom % 4) != 0, v, ($urandom % 3) != 0);
    end
    drain();
    chk(exp_q.size() == 0, "R11", "all accepted vectors delivered",
        128'(exp_q.size()), '0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

endmodule